// File: doc/BRIEF.md
# Two-Phase SCL Timing Generator

This block produces the serial clock of an I2C master from the system clock. It drives a pull-low request for the SCL line and emits single-cycle tick pulses that a byte engine uses to change SDA during the low phase and to sample it during the high phase. The phase lengths come from divider fields in two 32-bit register words. The words are passed in whole, and the block extracts only the fields it needs.

Two timing modes exist. In legacy mode one divider D describes a bit of four equal quarters. SCL is held low for two quarters and released for two quarters. In split mode the main divider sets the released (high) phase and a separate 12-bit field sets the low phase, so the duty cycle can be uneven, as fast mode needs (about 40% high, 60% low). In both modes a fixed input-filter latency of 15 system cycles is added to the high phase. The high phase only starts counting once the SCL line reads high, so a target that stretches the clock lengthens the bit.

Clearing the enable returns the generator to the start of a low phase. While disabled, the generator releases the line and stays quiet.

Top module: `scl_clk_gen`

## Requirements
- R1: While `gen_en` is 0 (and during reset), `scl_pull` and all four tick outputs are 0. In the first cycle after `gen_en` becomes 1, a low phase starts: `scl_pull` is 1 and `tick_fall` pulses.
- R2: The main divider D is 12 bits. Bits [9:0] are `ctl_word[21:12]` and bits [11:10] are `ctl_word[29:28]`. All other bits of `ctl_word` have no effect.
- R3: With `adr_word[28]` = 0 (legacy mode), the low phase lasts 2*D cycles and the high phase lasts 2*D+15 cycles when the line is not stretched.
- R4: With `adr_word[28]` = 1 (split mode), the low phase lasts L cycles and the high phase D+15 cycles, where L = `adr_word[27:16]`.
- R5: A value of zero in D or L is used as one.
- R6: `tick_fall` pulses in the first cycle of each low phase. `tick_lo_mid` pulses at offset floor(low/2) in that phase, while `scl_pull` is 1. When the low phase is one cycle long, the two pulses coincide.
- R7: `tick_rise` pulses in the first high-phase cycle in which `scl_in` reads 1. `tick_hi_mid` pulses floor(high/2) cycles after that first cycle, with `scl_pull` at 0.
- R8: At the start of the high phase, while `scl_in` reads 0, the high count does not advance and the line stays released. The bit is lengthened by exactly the number of held cycles.
- R9: In legacy mode, the low-phase field `adr_word[27:16]` has no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_en | input | 1 | Run the generator; 0 parks it at the start of a low phase |
| ctl_word | input | 32 | Control word holding the split main divider |
| adr_word | input | 32 | Word holding the low-phase count and the split-mode enable |
| scl_in | input | 1 | Observed SCL line level |
| scl_pull | output | 1 | 1 requests SCL driven low, 0 releases it |
| tick_fall | output | 1 | Pulse at the start of the low phase |
| tick_lo_mid | output | 1 | Pulse in the middle of the low phase (SDA change point) |
| tick_rise | output | 1 | Pulse when the high phase begins with the line seen high |
| tick_hi_mid | output | 1 | Pulse in the middle of the high phase (SDA sample point) |

## Verification
A wrong phase or count inside the generator shows up at the ports as a tick arriving in the wrong cycle or one that never arrives. Because every tick carries an exact expected cycle number, any error appears within one bit period. A stuck counter shows up as a missing `tick_fall` at most one period after it should have come. A stretch that is ignored shows up as `tick_rise` arriving while the line is still held low, in the very cycle the phase is released. A wrong field extraction or mode choice shifts the mid-phase ticks in the first bit after enable.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    // divider and counter widths
    localparam int DIV_W   = 12;
    localparam int CNT_W   = DIV_W + 2;
    localparam int WORD_W  = 32;

    // field placement inside the two register words
    localparam int CTL_DIV_POS   = 12;
    localparam int CTL_DIV_W     = 10;
    localparam int CTL_EXT_POS   = 28;
    localparam int CTL_EXT_W     = DIV_W - CTL_DIV_W;
    localparam int ADR_LOW_POS   = 16;
    localparam int ADR_SPLIT_POS = 28;

    // default input-filter latency folded into the high phase
    localparam int FILT_CYC_DEF  = 15;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] lo_len;
        logic [CNT_W-1:0] hi_len;
    } phase_len_t;

    typedef struct packed {
        logic fall;
        logic lo_mid;
        logic rise;
        logic hi_mid;
    } tick_t;

    function automatic logic [DIV_W-1:0] at_least_one(input logic [DIV_W-1:0] v);
        return (v == '0) ? DIV_W'(1) : v;
    endfunction

endpackage

// File: rtl/scl_div_decode.sv
module scl_div_decode
    import scl_gen_pkg::*;
#(
    parameter int FILT_CYC = FILT_CYC_DEF
) (
    input  logic [WORD_W-1:0] ctl_word,
    input  logic [WORD_W-1:0] adr_word,
    output phase_len_t        lens
);
    logic [DIV_W-1:0] div_raw;
    logic [DIV_W-1:0] low_raw;
    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] low_eff;
    logic             split_mode;
    logic [CNT_W-1:0] div_ext;
    logic [CNT_W-1:0] low_ext;

    // main divider is assembled from two separate fields
    assign div_raw    = {ctl_word[CTL_EXT_POS +: CTL_EXT_W],
                         ctl_word[CTL_DIV_POS +: CTL_DIV_W]};
    assign low_raw    = adr_word[ADR_LOW_POS +: DIV_W];
    assign split_mode = adr_word[ADR_SPLIT_POS];

    assign div_eff = at_least_one(div_raw);
    assign low_eff = at_least_one(low_raw);
    assign div_ext = CNT_W'(div_eff);
    assign low_ext = CNT_W'(low_eff);

    always_comb begin
        if (split_mode) begin
            lens.lo_len = low_ext;
            lens.hi_len = div_ext + CNT_W'(FILT_CYC);
        end else begin
            // two quarters low, two quarters high
            lens.lo_len = div_ext << 1;
            lens.hi_len = (div_ext << 1) + CNT_W'(FILT_CYC);
        end
    end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             gen_en,
    input  logic             scl_in,
    input  phase_len_t       lens,
    output phase_e           phase,
    output logic [CNT_W-1:0] cnt,
    output logic             hold_wait
);
    logic lo_done;
    logic hi_done;

    assign lo_done   = (cnt >= lens.lo_len - CNT_W'(1));
    assign hi_done   = (cnt >= lens.hi_len - CNT_W'(1));
    // high count waits at position zero until the line reads high
    assign hold_wait = gen_en && (phase == PH_HIGH) && (cnt == '0) && !scl_in;

    always_ff @(posedge clk) begin
        if (rst || !gen_en) begin
            phase <= PH_LOW;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_LOW: begin
                    if (lo_done) begin
                        phase <= PH_HIGH;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (hold_wait) begin
                        cnt <= cnt;
                    end else if (hi_done) begin
                        phase <= PH_LOW;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: begin
                    phase <= PH_LOW;
                    cnt   <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen
    import scl_gen_pkg::*;
(
    input  logic             gen_en,
    input  logic             scl_in,
    input  phase_e           phase,
    input  logic [CNT_W-1:0] cnt,
    input  phase_len_t       lens,
    output tick_t            ticks,
    output logic             scl_pull
);
    logic [CNT_W-1:0] lo_mid_pos;
    logic [CNT_W-1:0] hi_mid_pos;
    logic             in_low;
    logic             in_high;

    assign lo_mid_pos = lens.lo_len >> 1;
    assign hi_mid_pos = lens.hi_len >> 1;
    assign in_low     = gen_en && (phase == PH_LOW);
    assign in_high    = gen_en && (phase == PH_HIGH);

    assign scl_pull      = in_low;
    assign ticks.fall    = in_low  && (cnt == '0);
    assign ticks.lo_mid  = in_low  && (cnt == lo_mid_pos);
    assign ticks.rise    = in_high && (cnt == '0) && scl_in;
    assign ticks.hi_mid  = in_high && (cnt != '0) && (cnt == hi_mid_pos);

endmodule

// File: rtl/scl_clk_gen.sv
module scl_clk_gen
    import scl_gen_pkg::*;
#(
    parameter int FILT_CYC = FILT_CYC_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gen_en,
    input  logic [WORD_W-1:0] ctl_word,
    input  logic [WORD_W-1:0] adr_word,
    input  logic              scl_in,
    output logic              scl_pull,
    output logic              tick_fall,
    output logic              tick_lo_mid,
    output logic              tick_rise,
    output logic              tick_hi_mid
);
    phase_len_t       lens;
    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             hold_wait;
    tick_t            ticks;
    logic             unused_word_bits;

    // only the divider fields are consumed from the words
    assign unused_word_bits = ^{ctl_word, adr_word};

    scl_div_decode #(.FILT_CYC(FILT_CYC)) u_decode (
        .ctl_word (ctl_word),
        .adr_word (adr_word),
        .lens     (lens)
    );

    scl_phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .gen_en    (gen_en),
        .scl_in    (scl_in),
        .lens      (lens),
        .phase     (phase),
        .cnt       (cnt),
        .hold_wait (hold_wait)
    );

    scl_tick_gen u_ticks (
        .gen_en   (gen_en),
        .scl_in   (scl_in),
        .phase    (phase),
        .cnt      (cnt),
        .lens     (lens),
        .ticks    (ticks),
        .scl_pull (scl_pull)
    );

    assign tick_fall   = ticks.fall;
    assign tick_lo_mid = ticks.lo_mid;
    assign tick_rise   = ticks.rise;
    assign tick_hi_mid = ticks.hi_mid;

endmodule

// File: rtl/scl_clk_gen_chk.sv
module scl_clk_gen_chk (
    input logic clk,
    input logic rst,
    input logic gen_en,
    input logic scl_in,
    input logic scl_pull,
    input logic tick_fall,
    input logic tick_lo_mid,
    input logic tick_rise,
    input logic tick_hi_mid,
    input logic hold_wait
);
    // R1: disabled generator is silent and releases the line
    p_quiet_off_r1: assert property (@(posedge clk) disable iff (rst)
        !gen_en |-> !scl_pull && !tick_fall && !tick_lo_mid && !tick_rise && !tick_hi_mid);

    // R6: every new low phase opens with a fall tick
    p_fall_at_pull_r6: assert property (@(posedge clk) disable iff (rst)
        (gen_en && $rose(scl_pull)) |-> tick_fall);

    // R6: fall ticks never repeat on consecutive cycles
    p_single_fall_r6: assert property (@(posedge clk) disable iff (rst)
        tick_fall |=> !tick_fall);

    // R6: low-phase midpoint only while the line is pulled
    p_lo_mid_low_r6: assert property (@(posedge clk) disable iff (rst)
        tick_lo_mid |-> scl_pull);

    // R7: rise tick needs a released line that reads high
    p_rise_line_r7: assert property (@(posedge clk) disable iff (rst)
        tick_rise |-> (scl_in && !scl_pull));

    // R7: high-phase midpoint only while released
    p_hi_mid_high_r7: assert property (@(posedge clk) disable iff (rst)
        tick_hi_mid |-> !scl_pull);

    // R8: a stretched line keeps the generator released
    p_stretch_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (gen_en && hold_wait) |=> (!gen_en || !scl_pull));

endmodule

bind scl_clk_gen scl_clk_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .gen_en      (gen_en),
    .scl_in      (scl_in),
    .scl_pull    (scl_pull),
    .tick_fall   (tick_fall),
    .tick_lo_mid (tick_lo_mid),
    .tick_rise   (tick_rise),
    .tick_hi_mid (tick_hi_mid),
    .hold_wait   (hold_wait)
);

// File: tb/scl_clk_gen_test.sv
`timescale 1ns/1ps
module scl_clk_gen_test;

    typedef struct {
        int         cyc;
        logic [3:0] vec;   // {fall, lo_mid, rise, hi_mid}
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        gen_en;
    logic [31:0] ctl_word;
    logic [31:0] adr_word;
    logic        tgt_hold;
    logic        scl_in;
    logic        scl_pull;
    logic        tick_fall, tick_lo_mid, tick_rise, tick_hi_mid;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   mon_on = 1'b0;
    bit   finished = 1'b0;
    exp_t q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // wired bus: line low if the generator or a stretching target pulls it
    assign scl_in = !scl_pull && !tgt_hold;

    scl_clk_gen uut (
        .clk         (clk),
        .rst         (rst),
        .gen_en      (gen_en),
        .ctl_word    (ctl_word),
        .adr_word    (adr_word),
        .scl_in      (scl_in),
        .scl_pull    (scl_pull),
        .tick_fall   (tick_fall),
        .tick_lo_mid (tick_lo_mid),
        .tick_rise   (tick_rise),
        .tick_hi_mid (tick_hi_mid)
    );

    task automatic push_ev(input int c, input logic [3:0] v, input string tag);
        exp_t e;
        e.cyc = c;
        e.vec = v;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic check_quiet(input string tag);
        logic [4:0] act;
        act = {scl_pull, tick_fall, tick_lo_mid, tick_rise, tick_hi_mid};
        checks++;
        if (act !== 5'b0) begin
            errors++;
            $display("FAIL %s: quiet outputs actual=%b expected=00000", tag, act);
        end
    endtask

    // monitor: pops expected tick cycles and compares
    always @(negedge clk) begin
        logic [3:0] cur;
        if (mon_on && !finished) begin
            cur = {tick_fall, tick_lo_mid, tick_rise, tick_hi_mid};
            while (q.size() > 0 && q[0].cyc < cyc) begin
                checks++;
                errors++;
                $display("FAIL %s: cycle %0d ticks actual=none expected=%b",
                         q[0].tag, q[0].cyc, q[0].vec);
                void'(q.pop_front());
            end
            if (cur != 4'b0) begin
                checks++;
                if (q.size() > 0 && q[0].cyc == cyc) begin
                    if (cur !== q[0].vec) begin
                        errors++;
                        $display("FAIL %s: cycle %0d ticks actual=%b expected=%b",
                                 q[0].tag, cyc, cur, q[0].vec);
                    end
                    void'(q.pop_front());
                end else begin
                    errors++;
                    $display("FAIL R1: cycle %0d unexpected ticks actual=%b expected=0000",
                             cyc, cur);
                end
            end
            if (tick_lo_mid) begin
                checks++;
                if (scl_pull !== 1'b1) begin
                    errors++;
                    $display("FAIL R6: scl_pull at low midpoint actual=%b expected=1", scl_pull);
                end
            end
            if (tick_hi_mid) begin
                checks++;
                if (scl_pull !== 1'b0) begin
                    errors++;
                    $display("FAIL R7: scl_pull at high midpoint actual=%b expected=0", scl_pull);
                end
            end
        end
    end

    task automatic wait_cycle(input int target);
        do begin
            @(posedge clk);
            #1;
        end while (cyc < target);
    endtask

    // driver: program, enable, predict two bits plus the next fall, then disable
    task automatic run_case(input logic [31:0] cw, input logic [31:0] aw,
                            input int lo, input int hi, input int stretch,
                            input string ctag);
        int s;
        int base;
        int x;
        int rel;
        @(posedge clk);
        #1;
        s        = cyc;
        ctl_word = cw;
        adr_word = aw;
        tgt_hold = (stretch > 0);
        gen_en   = 1'b1;
        base = s;
        x    = stretch;
        for (int k = 0; k < 2; k++) begin
            push_ev(base, 4'b1000 | ((lo / 2 == 0) ? 4'b0100 : 4'b0000), {ctag, "+R6"});
            if (lo / 2 > 0) push_ev(base + lo / 2, 4'b0100, {ctag, "+R6"});
            push_ev(base + lo + x, 4'b0010, {ctag, "+R7"});
            push_ev(base + lo + x + hi / 2, 4'b0001, {ctag, "+R7"});
            base = base + lo + x + hi;
            x = 0;
        end
        push_ev(base, 4'b1000 | ((lo / 2 == 0) ? 4'b0100 : 4'b0000), {ctag, "+R6"});
        if (stretch > 0) begin
            rel = s + lo + stretch;
            wait_cycle(rel);
            tgt_hold = 1'b0;
        end
        wait_cycle(base + 1);
        gen_en = 1'b0;
        @(negedge clk);
        check_quiet({ctag, "+R1"});
        repeat (4) @(posedge clk);
        #1;
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL %s: leftover expected ticks actual=%0d expected=0", ctag, q.size());
            q.delete();
        end
    endtask

    initial begin
        rst      = 1'b1;
        gen_en   = 1'b0;
        ctl_word = '0;
        adr_word = '0;
        tgt_hold = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_quiet("R1 reset");
        @(posedge clk);
        #1;
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check_quiet("R1 idle");
        mon_on = 1'b1;

        // R3 and R9: legacy D=3, stray low field 5 ignored -> low 6, high 21
        run_case(32'h0000_3007, 32'h0005_0000, 6, 21, 0, "R3/R9");
        // R2: divider 1026 uses the upper field -> low 2052, high 2067
        run_case((32'd1 << 28) | (32'd2 << 12) | 32'h0000_0F00, 32'h0000_0000, 2052, 2067, 0, "R2");
        // R5: legacy zero divider -> low 2, high 17
        run_case(32'h0000_0000, 32'h0000_0000, 2, 17, 0, "R5 legacy");
        // R4: split H=25 L=37 -> low 37, high 40
        run_case(32'd25 << 12, (32'd1 << 28) | (32'd37 << 16), 37, 40, 0, "R4");
        // R5: split zeros -> low 1, high 16
        run_case(32'h0000_0000, 32'd1 << 28, 1, 16, 0, "R5 split");
        // R8: split H=10 L=12 with a 9-cycle stretch -> low 12, high 25
        run_case(32'd10 << 12, (32'd1 << 28) | (32'd12 << 16), 12, 25, 9, "R8");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        if (!finished && cyc > 100000) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: cycle actual=%0d expected<=100000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule